// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Sequencer

This block is the host-side sequencer that carries one floating-point coprocessor instruction across a shared 16-bit slave bus. A decoded instruction arrives as one command beat: its class, identification byte, operation word, the two operand sizes, flags marking each operand as floating-point and as held in a coprocessor register, and up to 64 bits of data per operand. The sequencer then makes bus transfers in a fixed order. It sends the identification byte, then the operation word, then whichever operand words the class and addressing call for. It then waits for the coprocessor's completion pulse and reads the status word. It finishes in one of four ways: it raises a trap request, it loads the flag bits, it reads back the result, or it gives up after a programmable wait.

The command input and the result output are valid/ready streams. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle, so an upstream stage stalls for as long as an instruction is in flight. The result is presented with `res_valid` and held unchanged until `res_ready` takes it, so a slow consumer stalls the sequencer in its last phase.

Each bus transfer is a request held by `bus_valid` until the slave answers with `bus_ready`. The completion line `spc_n` is open-drain and only ever read by this block: a pull-up holds it high, and the coprocessor pulls it low.

Top module: `copro_dispatch`

## Requirements
- R1: One instruction makes its transfers in this order: the identification byte, written with status code 2'b11 and zero-extended in the low byte; the operation word, written with code 2'b01; the operand words, written with code 2'b01; one status-word read with code 2'b10; and the result words, read with code 2'b01.
- R2: Items move least significant 16-bit word first. Each item takes a number of transfers that depends on its size code:
  - 0 (8 bits) or 1 (16 bits): one transfer. An 8-bit item carries zeros in bits 15:8 in both directions.
  - 2 (32 bits): two transfers.
  - 3 (64 bits): four transfers.
- R3: An operand with both its floating-point flag and its register flag set is not transferred. For classes 0 and 2, a register-held floating operand 2 also means no result is read. The register flag has no effect on a non-float operand.
- R4: The transfers depend on the class code:
  - 0 (two-operand arithmetic): sends operand 1 and then operand 2, and reads a result of operand 2's size.
  - 1 (compare): sends both operands and reads no result.
  - 2 (single-operand or conversion): sends operand 1 only, and reads a result of operand 2's size.
  - 3 (load status register): sends operand 1 as 32 bits whatever its size code, and reads no result.
  - 4 (store status register): sends no operand, and reads a 32-bit result.
- R5: After the last write, no transfer is requested until a low level on `spc_n` has been seen. The status read is requested two cycles after the first cycle in which `spc_n` is low.
- R6: If bit 0 of the status word is set, the sequencer does three things. It pulses `trap_req` for one cycle. It reads no result and gives no `flag_we`. It returns to idle.
- R7: For class 1 with status bit 0 clear, `flag_we` pulses for one cycle, and `flag_n`, `flag_z` and `flag_l` take status bits 7, 6 and 2 and hold them until the next such pulse.
- R8: With `timeout_limit` = L (L >= 1), if `spc_n` stays high, `timeout_err` pulses L+1 cycles after the cycle in which the last write was accepted. No status read follows, and the block returns to idle.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_status` and `bus_wdata` hold their values.
- R10: `cmd_ready` is high only while idle. It is low in the cycle after a command is accepted. `res_valid` and `res_data` hold until `res_ready` is seen.
- R11: After reset the block is idle:
  - `cmd_ready` is high.
  - `bus_valid`, `res_valid`, `trap_req`, `timeout_err` and `flag_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_class | input | 3 | Class code (R4) |
| cmd_id | input | 8 | Identification byte |
| cmd_opword | input | 16 | Operation word |
| cmd_sz1 | input | 2 | Operand 1 size code |
| cmd_sz2 | input | 2 | Operand 2 / result size code |
| cmd_flt1 | input | 1 | Operand 1 is floating-point |
| cmd_flt2 | input | 1 | Operand 2 is floating-point |
| cmd_reg1 | input | 1 | Operand 1 uses register-direct addressing |
| cmd_reg2 | input | 1 | Operand 2 uses register-direct addressing |
| cmd_data1 | input | 64 | Operand 1 value, low bits used |
| cmd_data2 | input | 64 | Operand 2 value, low bits used |
| timeout_limit | input | 16 | Completion wait limit in cycles |
| bus_valid | output | 1 | Bus transfer request |
| bus_ready | input | 1 | Slave completes the transfer |
| bus_write | output | 1 | 1 = write to coprocessor, 0 = read |
| bus_status | output | 2 | Status code of the transfer |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| spc_n | input | 1 | Completion line, pulled up, pulsed low |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | 64 | Result, zero-extended |
| trap_req | output | 1 | One-cycle slave trap request |
| timeout_err | output | 1 | One-cycle completion timeout |
| flag_we | output | 1 | One-cycle flag load strobe |
| flag_n | output | 1 | Loaded N flag |
| flag_z | output | 1 | Loaded Z flag |
| flag_l | output | 1 | Loaded L flag |

## Verification
Two situations are the hardest to reach from the ports:
- The wait window between the last write and the status read. The bench owns `spc_n`, so it can place the completion pulse a chosen number of cycles after the final write, or withhold it so that the timeout fires. It also demands silence on the bus for every cycle of that window.
- Operand skipping that removes every operand. Setting the float and register flags on both operands of an arithmetic command makes the sequencer go straight from the operation word to waiting, with no result read afterwards.

A slave ready pattern that stalls one cycle in three holds requests open across phase boundaries, and a result consumer that holds off for two cycles exercises result back-pressure.

// File: rtl/copro_pkg.sv
package copro_pkg;

  typedef enum logic [2:0] {
    CL_ARITH = 3'd0,
    CL_CMP   = 3'd1,
    CL_MONO  = 3'd2,
    CL_LDSR  = 3'd3,
    CL_STSR  = 3'd4
  } op_class_t;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd1;
  localparam logic [1:0] SZ_D = 2'd2;
  localparam logic [1:0] SZ_Q = 2'd3;

  localparam logic [1:0] ST_ID   = 2'b11;
  localparam logic [1:0] ST_XFER = 2'b01;
  localparam logic [1:0] ST_STAT = 2'b10;

  localparam int QBIT = 0;
  localparam int NBIT = 7;
  localparam int ZBIT = 6;
  localparam int LBIT = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_OPW, S_OP1, S_OP2, S_WAIT, S_STAT, S_RES, S_OUT
  } seq_state_t;

endpackage

// File: rtl/copro_plan.sv
module copro_plan
  import copro_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 3
) (
  input  logic [2:0]    cls,
  input  logic [1:0]    sz1,
  input  logic [1:0]    sz2,
  input  logic          flt1,
  input  logic          flt2,
  input  logic          reg1,
  input  logic          reg2,
  output logic [CW-1:0] n1,
  output logic [CW-1:0] n2,
  output logic [CW-1:0] nres,
  output logic [1:0]    esz1,
  output logic [1:0]    rsz,
  output logic          is_cmp
);

  function automatic logic [CW-1:0] words(input logic [1:0] sz);
    int bits;
    bits = 8 << sz;
    return CW'((bits + DW - 1) / DW);
  endfunction

  logic skip1, skip2;
  assign skip1 = flt1 & reg1;
  assign skip2 = flt2 & reg2;

  always_comb begin
    n1     = '0;
    n2     = '0;
    nres   = '0;
    esz1   = sz1;
    rsz    = sz2;
    is_cmp = 1'b0;
    case (op_class_t'(cls))
      CL_ARITH: begin
        n1   = skip1 ? '0 : words(sz1);
        n2   = skip2 ? '0 : words(sz2);
        nres = skip2 ? '0 : words(sz2);
      end
      CL_CMP: begin
        n1     = skip1 ? '0 : words(sz1);
        n2     = skip2 ? '0 : words(sz2);
        is_cmp = 1'b1;
      end
      CL_MONO: begin
        n1   = skip1 ? '0 : words(sz1);
        nres = skip2 ? '0 : words(sz2);
      end
      CL_LDSR: begin
        esz1 = SZ_D;
        n1   = words(SZ_D);
      end
      CL_STSR: begin
        rsz  = SZ_D;
        nres = words(SZ_D);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/copro_timer.sv
module copro_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  input  logic          spc_n,
  output logic          done,
  output logic          expire
);

  logic          spc_q;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spc_q <= 1'b1;
      cnt   <= '0;
    end else begin
      spc_q <= spc_n;
      if (!run) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  assign done   = run & ~spc_q;
  assign expire = run & spc_q & (cnt == limit - 1'b1);

  // R8: the wait never runs past the programmed limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && !done && limit != '0 |-> cnt < limit);

endmodule

// File: rtl/copro_dispatch.sv
module copro_dispatch
  import copro_pkg::*;
#(
  parameter int DW   = 16,
  parameter int MAXW = 64,
  parameter int TW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_class,
  input  logic [7:0]      cmd_id,
  input  logic [DW-1:0]   cmd_opword,
  input  logic [1:0]      cmd_sz1,
  input  logic [1:0]      cmd_sz2,
  input  logic            cmd_flt1,
  input  logic            cmd_flt2,
  input  logic            cmd_reg1,
  input  logic            cmd_reg2,
  input  logic [MAXW-1:0] cmd_data1,
  input  logic [MAXW-1:0] cmd_data2,
  input  logic [TW-1:0]   timeout_limit,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic            bus_write,
  output logic [1:0]      bus_status,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            spc_n,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [MAXW-1:0] res_data,
  output logic            trap_req,
  output logic            timeout_err,
  output logic            flag_we,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_l
);

  localparam int WPI = MAXW / DW;
  localparam int CW  = $clog2(WPI + 1);

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] w, input logic [1:0] sz);
    int bits;
    logic [DW-1:0] r;
    bits = 8 << sz;
    r = w;
    for (int i = 0; i < DW; i++)
      if (i >= bits) r[i] = 1'b0;
    return r;
  endfunction

  seq_state_t      state;
  logic [CW-1:0]   p_n1, p_n2, p_nres;
  logic [1:0]      p_esz1, p_rsz;
  logic            p_cmp;

  logic [CW-1:0]   n1, n2, nres, wcnt;
  logic [1:0]      sz1, sz2, rsz;
  logic            is_cmp;
  logic [7:0]      id_q;
  logic [DW-1:0]   opw_q;
  logic [MAXW-1:0] d1, d2, resbuf;
  logic            hs, t_done, t_expire;

  copro_plan #(.DW(DW), .CW(CW)) u_plan (
    .cls(cmd_class), .sz1(cmd_sz1), .sz2(cmd_sz2),
    .flt1(cmd_flt1), .flt2(cmd_flt2), .reg1(cmd_reg1), .reg2(cmd_reg2),
    .n1(p_n1), .n2(p_n2), .nres(p_nres), .esz1(p_esz1), .rsz(p_rsz),
    .is_cmp(p_cmp)
  );

  copro_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == S_WAIT), .limit(timeout_limit),
    .spc_n(spc_n), .done(t_done), .expire(t_expire)
  );

  assign hs = bus_valid & bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      n1          <= '0;
      n2          <= '0;
      nres        <= '0;
      wcnt        <= '0;
      sz1         <= '0;
      sz2         <= '0;
      rsz         <= '0;
      is_cmp      <= 1'b0;
      id_q        <= '0;
      opw_q       <= '0;
      d1          <= '0;
      d2          <= '0;
      resbuf      <= '0;
      trap_req    <= 1'b0;
      timeout_err <= 1'b0;
      flag_we     <= 1'b0;
      flag_n      <= 1'b0;
      flag_z      <= 1'b0;
      flag_l      <= 1'b0;
    end else begin
      trap_req    <= 1'b0;
      timeout_err <= 1'b0;
      flag_we     <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          n1     <= p_n1;
          n2     <= p_n2;
          nres   <= p_nres;
          sz1    <= p_esz1;
          sz2    <= cmd_sz2;
          rsz    <= p_rsz;
          is_cmp <= p_cmp;
          id_q   <= cmd_id;
          opw_q  <= cmd_opword;
          d1     <= cmd_data1;
          d2     <= cmd_data2;
          state  <= S_ID;
        end
        S_ID: if (hs) state <= S_OPW;
        S_OPW: if (hs) begin
          wcnt  <= '0;
          state <= (n1 != '0) ? S_OP1 : (n2 != '0) ? S_OP2 : S_WAIT;
        end
        S_OP1: if (hs) begin
          if (wcnt == n1 - CW'(1)) begin
            wcnt  <= '0;
            state <= (n2 != '0) ? S_OP2 : S_WAIT;
          end else begin
            wcnt <= wcnt + CW'(1);
          end
        end
        S_OP2: if (hs) begin
          if (wcnt == n2 - CW'(1)) begin
            wcnt  <= '0;
            state <= S_WAIT;
          end else begin
            wcnt <= wcnt + CW'(1);
          end
        end
        S_WAIT: begin
          if (t_done) begin
            state <= S_STAT;
          end else if (t_expire) begin
            timeout_err <= 1'b1;
            state       <= S_IDLE;
          end
        end
        S_STAT: if (hs) begin
          if (bus_rdata[QBIT]) begin
            trap_req <= 1'b1;
            state    <= S_IDLE;
          end else begin
            if (is_cmp) begin
              flag_we <= 1'b1;
              flag_n  <= bus_rdata[NBIT];
              flag_z  <= bus_rdata[ZBIT];
              flag_l  <= bus_rdata[LBIT];
            end
            if (nres != '0) begin
              wcnt   <= '0;
              resbuf <= '0;
              state  <= S_RES;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_RES: if (hs) begin
          resbuf[DW*int'(wcnt) +: DW] <= narrow(bus_rdata, rsz);
          if (wcnt == nres - CW'(1)) state <= S_OUT;
          else                      wcnt  <= wcnt + CW'(1);
        end
        S_OUT: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_valid  = 1'b0;
    bus_write  = 1'b0;
    bus_status = ST_XFER;
    bus_wdata  = '0;
    case (state)
      S_ID: begin
        bus_valid  = 1'b1;
        bus_write  = 1'b1;
        bus_status = ST_ID;
        bus_wdata  = {{(DW-8){1'b0}}, id_q};
      end
      S_OPW: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_wdata = opw_q;
      end
      S_OP1: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_wdata = narrow(d1[DW*int'(wcnt) +: DW], sz1);
      end
      S_OP2: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_wdata = narrow(d2[DW*int'(wcnt) +: DW], sz2);
      end
      S_STAT: begin
        bus_valid  = 1'b1;
        bus_status = ST_STAT;
      end
      S_RES: bus_valid = 1'b1;
      default: ;
    endcase
  end

  assign cmd_ready = (state == S_IDLE);
  assign res_valid = (state == S_OUT);
  assign res_data  = resbuf;

  // R9: a stalled bus request keeps every field
  p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) &&
    $stable(bus_status) && $stable(bus_wdata));

  // R10: result held under back-pressure
  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R10: a command is only offered to an idle bus
  p_cmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_valid && !res_valid);

  // R5: a status read begins only out of the wait phase
  p_stat_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) && bus_status == ST_STAT |-> $past(state) == S_WAIT);

  // R6: a trap closes the instruction without result or flags
  p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !bus_valid && !res_valid && !flag_we);

  // R8: a timeout comes only from waiting
  p_timeout_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> $past(state) == S_WAIT && !bus_valid);

endmodule

// File: tb/sim_copro_dispatch.sv
module sim_copro_dispatch;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready;
  logic [2:0]  cmd_class;
  logic [7:0]  cmd_id;
  logic [15:0] cmd_opword;
  logic [1:0]  cmd_sz1, cmd_sz2;
  logic        cmd_flt1, cmd_flt2, cmd_reg1, cmd_reg2;
  logic [63:0] cmd_data1, cmd_data2;
  logic [15:0] timeout_limit;
  logic        bus_valid, bus_ready, bus_write;
  logic [1:0]  bus_status;
  logic [15:0] bus_wdata, bus_rdata;
  logic        spc_n, res_valid, res_ready;
  logic [63:0] res_data;
  logic        trap_req, timeout_err, flag_we, flag_n, flag_z, flag_l;

  copro_dispatch u0 (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  localparam int LIM = 25;

  typedef struct { bit wr; logic [1:0] st; logic [15:0] d; } xfer_t;
  xfer_t       expq[$];
  logic [15:0] rdq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nwords(input logic [1:0] sz);
    return ((8 << sz) + 15) / 16;
  endfunction

  task automatic push_item(input logic [63:0] v, input logic [1:0] sz, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = v[i*16 +: 16];
      if (sz == 2'd0) w[15:8] = 8'h00;
      expq.push_back('{1'b1, 2'b01, w});
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_instr(input string tag, input logic [2:0] cls,
      input logic [1:0] s1, input logic [1:0] s2, input bit f1, input bit f2,
      input bit r1, input bit r2, input logic [63:0] d1, input logic [63:0] d2,
      input logic [15:0] stw, input logic [63:0] resv, input int spcdel,
      input bit no_spc);
    int n1, n2, nr, nwr, popped, wcyc, rhold, tmo_cyc;
    int trap_seen, flag_seen, tmo_seen;
    bit skip1, skip2, quit, exp_res, got_res, wdone, fin;
    logic [1:0] e1, rs;
    logic [63:0] expres, prevres;
    logic [7:0] id;
    logic [15:0] opw;

    expq.delete();
    rdq.delete();
    id  = {5'b10110, cls};
    opw = {13'h1BE5, cls};
    skip1 = f1 && r1;
    skip2 = f2 && r2;
    e1 = (cls == 3'd3) ? 2'd2 : s1;
    rs = (cls == 3'd4) ? 2'd2 : s2;
    n1 = 0; n2 = 0; nr = 0;
    case (cls)
      3'd0: begin n1 = skip1 ? 0 : nwords(s1); n2 = skip2 ? 0 : nwords(s2);
                  nr = skip2 ? 0 : nwords(s2); end
      3'd1: begin n1 = skip1 ? 0 : nwords(s1); n2 = skip2 ? 0 : nwords(s2); end
      3'd2: begin n1 = skip1 ? 0 : nwords(s1); nr = skip2 ? 0 : nwords(s2); end
      3'd3: n1 = 2;
      3'd4: nr = 2;
      default: ;
    endcase
    expq.push_back('{1'b1, 2'b11, {8'h00, id}});
    expq.push_back('{1'b1, 2'b01, opw});
    push_item(d1, e1, n1);
    push_item(d2, s2, n2);
    nwr  = expq.size();
    quit = stw[0];
    if (!no_spc) expq.push_back('{1'b0, 2'b10, 16'h0});
    expres = 64'h0;
    if (!no_spc && !quit) begin
      for (int i = 0; i < nr; i++) begin
        expq.push_back('{1'b0, 2'b01, 16'h0});
        rdq.push_back(resv[i*16 +: 16]);
        expres[i*16 +: 16] = resv[i*16 +: 16];
      end
      if (rs == 2'd0) expres = expres & 64'hFF;
    end
    exp_res = !no_spc && !quit && nr > 0;

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10", {tag, " ready before command"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_class = cls; cmd_id = id; cmd_opword = opw;
    cmd_sz1 = s1; cmd_sz2 = s2; cmd_flt1 = f1; cmd_flt2 = f2;
    cmd_reg1 = r1; cmd_reg2 = r2; cmd_data1 = d1; cmd_data2 = d2;
    popped = 0; wcyc = 0; rhold = 0; tmo_cyc = -1;
    trap_seen = 0; flag_seen = 0; tmo_seen = 0;
    got_res = 0; wdone = 0; fin = 0; prevres = '0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (cyc == 0)
        chk(cmd_ready == 1'b0, "R10", {tag, " busy after accept"}, cmd_ready, 0);
      if (wdone) wcyc++;
      if (trap_req) trap_seen++;
      if (timeout_err) begin tmo_seen++; tmo_cyc = wcyc; end
      if (flag_we) begin
        flag_seen++;
        chk({flag_n, flag_z, flag_l} == {stw[7], stw[6], stw[2]}, "R7",
            {tag, " flags"}, {flag_n, flag_z, flag_l}, {stw[7], stw[6], stw[2]});
      end
      if (res_valid) begin
        if (rhold == 0) prevres = res_data;
        if (rhold < 2) begin
          chk(res_data == prevres, "R10", {tag, " result held"}, res_data, prevres);
          res_ready = 1'b0;
          rhold++;
        end else begin
          chk(res_data == expres, "R2", {tag, " result value"}, res_data, expres);
          res_ready = 1'b1;
          got_res = 1;
        end
      end else begin
        res_ready = 1'b0;
      end
      if (wdone && !no_spc) begin
        if (wcyc == spcdel) spc_n = 1'b0;
        if (wcyc == spcdel + 2) spc_n = 1'b1;
      end
      if (wdone && (no_spc || wcyc <= spcdel + 1))
        chk(bus_valid == 1'b0, "R5", {tag, " bus quiet while waiting"}, bus_valid, 0);
      bus_ready = ((cyc % 3) != 2);
      if (bus_valid && bus_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R1", {tag, " unexpected transfer"}, {bus_write, bus_status}, 0);
        end else begin
          xfer_t e;
          e = expq.pop_front();
          popped++;
          chk(bus_write == e.wr && bus_status == e.st, "R1",
              {tag, " direction/status"}, {bus_write, bus_status}, {e.wr, e.st});
          if (e.wr)
            chk(bus_wdata == e.d, "R2", {tag, " write word"}, bus_wdata, e.d);
          else if (e.st == 2'b10)
            bus_rdata = stw;
          else if (rdq.size() != 0)
            bus_rdata = rdq.pop_front();
          if (popped == nwr) begin wdone = 1; wcyc = 0; end
        end
      end
      if (cyc > 0 && expq.size() == 0 && cmd_ready && got_res == exp_res &&
          (!no_spc || tmo_seen > 0))
        fin = 1;
    end
    bus_ready = 1'b0;
    res_ready = 1'b0;
    spc_n = 1'b1;
    chk(fin, "R1", {tag, " sequence completed"}, fin, 1);
    chk(trap_seen == int'(quit && !no_spc), "R6", {tag, " trap pulses"},
        trap_seen, quit && !no_spc);
    chk(flag_seen == int'(cls == 3'd1 && !quit && !no_spc), "R7", {tag, " flag strobes"},
        flag_seen, cls == 3'd1 && !quit && !no_spc);
    chk(tmo_seen == int'(no_spc), "R8", {tag, " timeout pulses"}, tmo_seen, no_spc);
    if (no_spc)
      chk(tmo_cyc == LIM + 1, "R8", {tag, " timeout delay"}, tmo_cyc, LIM + 1);
    chk(got_res == exp_res, "R4", {tag, " result delivered"}, got_res, exp_res);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!bus_valid && !res_valid && !trap_req && !timeout_err && !flag_we, "R6",
          {tag, " idle after end"}, {bus_valid, res_valid, trap_req, timeout_err, flag_we}, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_class = '0; cmd_id = '0; cmd_opword = '0;
    cmd_sz1 = '0; cmd_sz2 = '0; cmd_flt1 = 0; cmd_flt2 = 0; cmd_reg1 = 0; cmd_reg2 = 0;
    cmd_data1 = '0; cmd_data2 = '0; timeout_limit = 16'(LIM);
    bus_ready = 1'b0; bus_rdata = '0; spc_n = 1'b1; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !bus_valid && !res_valid && !trap_req && !timeout_err && !flag_we,
        "R11", "reset state", {cmd_ready, bus_valid, res_valid, trap_req, timeout_err, flag_we},
        6'b100000);

    // R1 R2 R4: long + long arithmetic, everything in memory
    run_instr("arith_long", 3'd0, 2'd3, 2'd3, 1, 1, 0, 0,
              64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
              16'h0000, 64'hAAAA_BBBB_CCCC_DDDD, 3, 0);
    // R3: operand 1 in a coprocessor register, single precision
    run_instr("arith_reg1", 3'd0, 2'd2, 2'd2, 1, 1, 1, 0,
              64'hDEAD_BEEF_0BAD_F00D, 64'h0000_0000_1234_5678,
              16'h0000, 64'h0000_0000_9ABC_DEF0, 2, 0);
    // R3: both operands in registers, no operand and no result traffic
    run_instr("arith_allreg", 3'd0, 2'd3, 2'd3, 1, 1, 1, 1,
              64'h1, 64'h2, 16'h0000, 64'h0, 1, 0);
    // R3 R2: byte integer operand with register flag still sent, long result
    run_instr("mono_byte_in", 3'd2, 2'd0, 2'd3, 0, 1, 1, 0,
              64'h0000_0000_0000_ABCD, 64'h0,
              16'h0000, 64'h0102_0304_0506_0708, 4, 0);
    // R2 R4: float to 16-bit integer conversion
    run_instr("mono_word_out", 3'd2, 2'd2, 2'd1, 1, 0, 0, 1,
              64'h0000_0000_4049_0FDB, 64'h0, 16'h0000, 64'h0000_0000_0000_C0DE, 5, 0);
    // R2: byte result, upper read bits discarded
    run_instr("mono_byte_out", 3'd2, 2'd2, 2'd0, 1, 0, 0, 0,
              64'h0000_0000_3F80_0000, 64'h0, 16'h0000, 64'h0000_0000_0000_7E5A, 2, 0);
    // R7: compare loads N and L, no result
    run_instr("cmp_nl", 3'd1, 2'd2, 2'd2, 1, 1, 0, 0,
              64'h0000_0000_4000_0000, 64'h0000_0000_C000_0000,
              16'h0084, 64'h0, 3, 0);
    // R7: compare loads Z only
    run_instr("cmp_z", 3'd1, 2'd3, 2'd3, 1, 1, 0, 1,
              64'h0123_4567_89AB_CDEF, 64'h0, 16'hFF40 & 16'h00C4 & 16'h0040, 64'h0, 1, 0);
    // R6: quit during arithmetic, result never read
    run_instr("arith_quit", 3'd0, 2'd2, 2'd2, 1, 1, 0, 0,
              64'h0000_0000_1357_9BDF, 64'h0000_0000_2468_ACE0,
              16'h00C5, 64'h0000_0000_FFFF_FFFF, 2, 0);
    // R6: quit during compare, no flag load
    run_instr("cmp_quit", 3'd1, 2'd2, 2'd2, 1, 1, 0, 0,
              64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002,
              16'h00C1, 64'h0, 2, 0);
    // R4: load status register forces 32-bit operand
    run_instr("ldsr", 3'd3, 2'd0, 2'd0, 0, 0, 0, 0,
              64'hFFFF_FFFF_0F0F_A5A5, 64'h0, 16'h0000, 64'h0, 2, 0);
    // R4: store status register reads a 32-bit value
    run_instr("stsr", 3'd4, 2'd0, 2'd0, 0, 0, 0, 0,
              64'h0, 64'h0, 16'h0000, 64'h0000_0000_0003_8421, 6, 0);
    // R8: no completion pulse
    run_instr("timeout", 3'd0, 2'd1, 2'd1, 0, 0, 0, 0,
              64'h0000_0000_0000_4321, 64'h0000_0000_0000_8765,
              16'h0000, 64'h0, 1, 1);
    // R1: a normal instruction still works after the timeout
    run_instr("after_timeout", 3'd2, 2'd1, 2'd1, 0, 0, 0, 0,
              64'h0000_0000_0000_BEEF, 64'h0, 16'h0000, 64'h0000_0000_0000_FACE, 2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule